// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets logic running on a single clock read and write an external asynchronous static RAM of 32K words by 16 bits. The RAM side has an active-low chip select, output enable and write strobe, and one active-low enable per byte lane. The host side is a single-outstanding request port. The host presents a word address, write data, a per-lane byte mask and a read/write flag. It gets back a one-cycle acknowledge, which carries the captured word on reads.

Every analog limit of the RAM is a nanosecond parameter. The block turns each limit into a whole number of clock cycles from the clock-period parameter, so one RTL serves any clock. The write data bus is split into a data output, per-lane drive enables and a data input, so the pad ring owns the actual tristate buffers. Idle cycles keep chip select high, which lets the RAM power itself down.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, the chip select, output enable, write strobe and both lane enables are high (inactive), all lane drive enables are 0, ready is 1 and ack is 0.
- R2: A read with a nonzero mask holds chip select and output enable low and the write strobe high for exactly RD_CYC cycles, starting in the cycle after the request is accepted. The address is held on the RAM address pins throughout, and lane enable bit i is low exactly when mask bit i is 1.
- R3: The word returned with a read ack carries the RAM data-bus byte for every lane whose mask bit is 1. Lane 0 is bits 7:0 and lane 1 is bits 15:8. Every lane whose mask bit is 0 reads as 8'h00.
- R4: A write with a nonzero mask holds chip select, write strobe and the masked lane enables low for exactly WR_CYC cycles after acceptance. Output enable stays high for the whole transaction.
- R5: During a write, lane drive enable i is 1 only for masked lanes. It turns on DRV_CYC cycles after the write strobe falls and turns off one cycle after the strobe rises. It is never 1 while output enable is low.
- R6: The RAM address and the driven write data stay constant while the strobes or drivers are active. Only the masked lanes of the addressed word change in the RAM.
- R7: A request with mask 2'b00 is acknowledged in the cycle after acceptance. It produces no strobe and no driver activity, and it leaves the RAM unchanged.
- R8: Ready is 1 only while the controller is idle. A request is taken when request and ready are both 1. Ack is a single-cycle pulse: at sample RD_CYC+1 after acceptance for reads and at sample WR_CYC+2 for writes.
- R9: RD_CYC is the ceiling of max(read cycle, address access, output-enable access) divided by CLK_NS. WR_CYC is the largest of the ceilings of strobe width, address setup to write end and write cycle, and DRV_CYC plus the data-setup ceiling. DRV_CYC is the ceiling of the bus-release time after the strobe falls, and at least 1. Elaboration stops if any nonzero limit would round to zero cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, taken when ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Byte mask, bit i selects lane i |
| host_ready | output | 1 | Controller idle |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read word, valid with ack |
| mem_addr | output | 15 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_be_n | output | 2 | RAM lane enables, active low, bit i = lane i |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the RAM |

## Verification
The bench runs the controller at a 4 ns period, so every count is longer than one cycle and rounding errors show. It first writes all 64 words of a small window, cycling the mask through both-lanes, low-only and high-only. It then reads every word back under all three nonzero masks. A lane written when it should not have been, or a lane left stale, shows up as a difference against the arithmetic expected image. Every transaction is traced cycle by cycle against the windows for strobes, drivers and ack, so an off-by-one in any count is caught. Mask-zero requests and a reset in mid-write cover the cases that must leave no trace on the RAM.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_READ    = 2'd1,
      ST_WSTROBE = 2'd2,
      ST_WREL    = 2'd3
   } ctl_state_t;

   // Whole clock cycles needed to cover t_ns at a period of clk_ns.
   function automatic int cyc_of(input int t_ns, input int clk_ns);
      return (t_ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (rst || clear)
         count <= '0;
      else if (count != TOP)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/sram_lane_lanes.sv
module sram_lane_lanes #(
   parameter int LANES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               drv_set,
   input  logic               drv_clr,
   input  logic               cap_en,
   input  logic [LANES-1:0]   mask,
   input  logic [LANES*8-1:0] wdata,
   input  logic [LANES*8-1:0] dq_i,
   output logic [LANES*8-1:0] dq_o,
   output logic [LANES-1:0]   dq_oe,
   output logic [LANES*8-1:0] rdata
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic       oe_r;
      logic [7:0] rd_r;

      always_ff @(posedge clk) begin
         if (rst)
            oe_r <= 1'b0;
         else if (drv_clr)
            oe_r <= 1'b0;
         else if (drv_set)
            oe_r <= mask[i];
      end

      always_ff @(posedge clk) begin
         if (rst)
            rd_r <= 8'h00;
         else if (cap_en)
            rd_r <= mask[i] ? dq_i[i*8 +: 8] : 8'h00;
      end

      assign dq_oe[i]         = oe_r;
      assign rdata[i*8 +: 8]  = rd_r;
      assign dq_o[i*8 +: 8]   = wdata[i*8 +: 8];
   end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 16,
   parameter int CLK_NS    = 10,
   parameter int T_RC_NS   = 10,
   parameter int T_AA_NS   = 10,
   parameter int T_DOE_NS  = 5,
   parameter int T_WC_NS   = 10,
   parameter int T_PWE_NS  = 7,
   parameter int T_AW_NS   = 7,
   parameter int T_SD_NS   = 5,
   parameter int T_WZ_NS   = 5,
   localparam int LANES    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [LANES-1:0]  host_mask,
   output logic              host_ready,
   output logic              host_ack,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_be_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic [LANES-1:0]  mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   // Limits converted to clock cycles.
   localparam int RC_CYC  = cyc_of(T_RC_NS,  CLK_NS);
   localparam int AA_CYC  = cyc_of(T_AA_NS,  CLK_NS);
   localparam int DOE_CYC = cyc_of(T_DOE_NS, CLK_NS);
   localparam int WC_CYC  = cyc_of(T_WC_NS,  CLK_NS);
   localparam int PWE_CYC = cyc_of(T_PWE_NS, CLK_NS);
   localparam int AW_CYC  = cyc_of(T_AW_NS,  CLK_NS);
   localparam int SD_CYC  = cyc_of(T_SD_NS,  CLK_NS);
   localparam int DRV_CYC = max2(1, cyc_of(T_WZ_NS, CLK_NS));
   localparam int RD_CYC  = max2(max2(RC_CYC, AA_CYC), DOE_CYC);
   localparam int WR_CYC  = max2(max2(PWE_CYC, AW_CYC),
                                 max2(WC_CYC, DRV_CYC + SD_CYC));
   localparam int CNT_W   = $clog2(max2(RD_CYC, WR_CYC) + 1) + 1;

   localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRV_CYC - 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_lane_ctrl: CLK_NS must be positive");
   end
   if (DATA_W % 8 != 0 || LANES < 1) begin : g_bad_width
      $error("sram_lane_ctrl: DATA_W must be a nonzero multiple of 8");
   end
   if (RC_CYC < 1 || AA_CYC < 1 || WC_CYC < 1 || PWE_CYC < 1 ||
       AW_CYC < 1 || SD_CYC < 1) begin : g_bad_timing
      $error("sram_lane_ctrl: a nonzero timing limit rounds to zero cycles");
   end

   ctl_state_t           state;
   logic [CNT_W-1:0]     cnt;
   logic [DATA_W-1:0]    wdata_q;
   logic [LANES-1:0]     mask_q;
   logic                 drv_set, drv_clr, cap_en;

   sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .clear (state == ST_IDLE),
      .count (cnt)
   );

   assign drv_set = (state == ST_WSTROBE) && (cnt == DRV_LAST);
   assign drv_clr = (state == ST_WREL);
   assign cap_en  = (state == ST_READ) && (cnt == RD_LAST);

   sram_lane_lanes #(.LANES(LANES)) u_lanes (
      .clk     (clk),
      .rst     (rst),
      .drv_set (drv_set),
      .drv_clr (drv_clr),
      .cap_en  (cap_en),
      .mask    (mask_q),
      .wdata   (wdata_q),
      .dq_i    (mem_dq_i),
      .dq_o    (mem_dq_o),
      .dq_oe   (mem_dq_oe),
      .rdata   (host_rdata)
   );

   assign host_ready = (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         mem_ce_n <= 1'b1;
         mem_oe_n <= 1'b1;
         mem_we_n <= 1'b1;
         mem_be_n <= '1;
         mem_addr <= '0;
         wdata_q  <= '0;
         mask_q   <= '0;
         host_ack <= 1'b0;
      end else begin
         host_ack <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (host_req) begin
                  mem_addr <= host_addr;
                  wdata_q  <= host_wdata;
                  mask_q   <= host_mask;
                  if (host_mask == '0) begin
                     host_ack <= 1'b1;
                  end else begin
                     mem_ce_n <= 1'b0;
                     mem_be_n <= ~host_mask;
                     if (host_wr) begin
                        mem_we_n <= 1'b0;
                        state    <= ST_WSTROBE;
                     end else begin
                        mem_oe_n <= 1'b0;
                        state    <= ST_READ;
                     end
                  end
               end
            end
            ST_READ: begin
               if (cnt == RD_LAST) begin
                  mem_ce_n <= 1'b1;
                  mem_oe_n <= 1'b1;
                  mem_be_n <= '1;
                  host_ack <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
            ST_WSTROBE: begin
               if (cnt == WR_LAST) begin
                  mem_we_n <= 1'b1;
                  mem_ce_n <= 1'b1;
                  mem_be_n <= '1;
                  state    <= ST_WREL;
               end
            end
            ST_WREL: begin
               host_ack <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
   parameter int ADDR_W = 15,
   parameter int LANES  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              host_ready,
   input logic              host_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [LANES-1:0]  mem_be_n,
   input logic [LANES*8-1:0] mem_dq_o,
   input logic [LANES-1:0]  mem_dq_oe
);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (mem_ce_n && mem_oe_n && mem_we_n && (&mem_be_n) &&
               mem_dq_oe == '0 && !host_ack));

   // R2
   read_qual_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n && !(&mem_be_n)));

   // R4
   write_qual_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && !(&mem_be_n)));

   // R5
   drv_no_contention_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_dq_oe != '0) |-> mem_oe_n);

   // R5
   drv_release_chk: assert property (@(posedge clk) disable iff (rst)
      ((mem_dq_oe != '0) && mem_we_n) |-> $past(!mem_we_n));

   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R6
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((mem_dq_oe != '0) && $past(mem_dq_oe != '0)) |-> $stable(mem_dq_o));

   // R8
   ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      host_ack |=> !host_ack);

   // R8
   ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
      host_ack |-> host_ready);
endmodule

bind sram_lane_ctrl sram_lane_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .host_ready (host_ready),
   .host_ack   (host_ack),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_be_n   (mem_be_n),
   .mem_dq_o   (mem_dq_o),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int P_NS       = 4;

   function automatic int cdiv(input int t, input int p);
      return (t + p - 1) / p;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // R9: expected counts from the limits 10,10,5 (read) and 10,7,7,5,5 (write).
   localparam int RD_E  = mx(mx(cdiv(10, P_NS), cdiv(10, P_NS)), cdiv(5, P_NS));
   localparam int DRV_E = mx(1, cdiv(5, P_NS));
   localparam int WR_E  = mx(mx(cdiv(7, P_NS), cdiv(7, P_NS)),
                             mx(cdiv(10, P_NS), DRV_E + cdiv(5, P_NS)));

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_req = 1'b0, host_wr = 1'b0;
   logic [14:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [1:0]  host_mask = '0;
   logic        host_ready, host_ack;
   logic [15:0] host_rdata;
   logic [14:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n;
   logic [1:0]  mem_be_n, mem_dq_oe;
   logic [15:0] mem_dq_o, mem_dq_i;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [15:0] model   [64];
   logic [15:0] exp_mem [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_lane_ctrl #(.CLK_NS(P_NS)) dut (
      .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
      .host_ready(host_ready), .host_ack(host_ack), .host_rdata(host_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   // RAM model: drives selected lanes on read, garbage elsewhere.
   always_comb begin
      for (int i = 0; i < 2; i++) begin
         if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[i])
            mem_dq_i[i*8 +: 8] = model[mem_addr[5:0]][i*8 +: 8];
         else
            mem_dq_i[i*8 +: 8] = 8'hA5;
      end
   end

   always @(negedge clk) begin
      if (!mem_ce_n && !mem_we_n) begin
         for (int i = 0; i < 2; i++)
            if (!mem_be_n[i] && mem_dq_oe[i])
               model[mem_addr[5:0]][i*8 +: 8] <= mem_dq_o[i*8 +: 8];
      end
   end

   function automatic logic [15:0] init_word(input int a);
      return 16'((a * 16'h1357) ^ 16'hC0DE);
   endfunction

   function automatic logic [15:0] lane_mask(input logic [1:0] m);
      return {{8{m[1]}}, {8{m[0]}}};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic txn(input bit wr, input logic [14:0] a, input logic [15:0] d,
                      input logic [1:0] m);
      int  n;
      int  ack_at;
      int  strb_end;
      bit  ok_strb = 1, ok_drv = 1, ok_rdy = 1, ok_hold = 1;
      logic [1:0] drv_exp;
      ack_at   = (m == 2'b00) ? 1 : (wr ? WR_E + 2 : RD_E + 1);
      strb_end = (m == 2'b00) ? 0 : (wr ? WR_E : RD_E);
      @(negedge clk);
      chk(host_ready === 1'b1 && host_ack === 1'b0, "R8 idle before request",
          {30'd0, host_ready, host_ack}, 32'd2);
      host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; host_mask = m;
      @(negedge clk);
      host_req = 1'b0;
      host_wdata = ~d;
      n = 1;
      while (1) begin
         if (n <= strb_end) begin
            if (mem_ce_n !== 1'b0 || mem_be_n !== ~m) ok_strb = 0;
            if (wr  && (mem_we_n !== 1'b0 || mem_oe_n !== 1'b1)) ok_strb = 0;
            if (!wr && (mem_oe_n !== 1'b0 || mem_we_n !== 1'b1)) ok_strb = 0;
            if (mem_addr !== a) ok_hold = 0;
         end else begin
            if (mem_ce_n !== 1'b1 || mem_oe_n !== 1'b1 || mem_we_n !== 1'b1 ||
                mem_be_n !== 2'b11) ok_strb = 0;
         end
         drv_exp = (wr && m != 2'b00 && n >= DRV_E + 1 && n <= WR_E + 1) ? m : 2'b00;
         if (mem_dq_oe !== drv_exp) ok_drv = 0;
         if (drv_exp != 2'b00 && ((mem_dq_o ^ d) & lane_mask(m)) != 16'h0) ok_hold = 0;
         if (host_ready !== (n >= ack_at)) ok_rdy = 0;
         if (host_ack === 1'b1 || n >= ack_at) break;
         n++;
         @(negedge clk);
      end
      if (m == 2'b00)
         chk(ok_strb && ok_drv, "R7 mask zero gives no RAM cycle", {30'd0, mem_dq_oe}, 32'd0);
      else if (wr)
         chk(ok_strb, "R4 R9 write strobe window", n, ack_at);
      else
         chk(ok_strb, "R2 R9 read strobe window", n, ack_at);
      chk(ok_drv, "R5 lane driver window", {30'd0, mem_dq_oe}, {30'd0, drv_exp});
      chk(ok_hold, "R6 address and data held", {17'd0, mem_addr}, {17'd0, a});
      chk(ok_rdy && host_ack === 1'b1 && n == ack_at, "R8 ack timing", n, ack_at);
      if (!wr && m != 2'b00)
         chk(host_rdata === (exp_mem[a[5:0]] & lane_mask(m)), "R3 read lane data",
             {16'd0, host_rdata}, {16'd0, exp_mem[a[5:0]] & lane_mask(m)});
      if (wr && m != 2'b00)
         exp_mem[a[5:0]] = (exp_mem[a[5:0]] & ~lane_mask(m)) | (d & lane_mask(m));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         model[i]   = init_word(i);
         exp_mem[i] = init_word(i);
      end
      repeat (3) @(negedge clk);
      // R1
      chk(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && mem_dq_oe == 2'b00
          && host_ready && !host_ack, "R1 reset state",
          {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 32'h1F);
      rst = 1'b0;

      // Write sweep, masks cycling 3,1,2.
      for (int a = 0; a < 64; a++)
         txn(1'b1, 15'(a), 16'((a * 16'h0101) ^ 16'h5A3C), 2'((a % 3 == 0) ? 3 : a % 3));

      // R7: mask zero write and read leave the word untouched.
      txn(1'b1, 15'd5, 16'hFFFF, 2'b00);
      txn(1'b0, 15'd5, 16'h0000, 2'b00);
      txn(1'b0, 15'd5, 16'h0000, 2'b11);

      // Read sweep under all nonzero masks (R3, R6).
      for (int a = 0; a < 64; a++)
         for (int m = 1; m < 4; m++)
            txn(1'b0, 15'(a), 16'h0000, 2'(m));

      // Upper address bits pass through unchanged.
      txn(1'b1, 15'h7FC0 | 15'd9, 16'h1234, 2'b11);
      txn(1'b0, 15'h7FC0 | 15'd9, 16'h0000, 2'b11);

      // R1: reset in the middle of a write strobe.
      @(negedge clk);
      host_req = 1'b1; host_wr = 1'b1; host_addr = 15'd63; host_wdata = 16'hBEEF;
      host_mask = 2'b11;
      @(negedge clk);
      host_req = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && mem_dq_oe == 2'b00
          && host_ready && !host_ack, "R1 reset during write",
          {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, 32'h1F);
      rst = 1'b0;
      txn(1'b0, 15'd11, 16'h0000, 2'b11);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule